// File: doc/BRIEF.md
# Byte-Serial CRC-16 Engine with Reflected Mode

This engine computes a 16-bit cyclic redundancy check over a message presented one byte per clock. It uses the generator x^16 + x^12 + x^5 + 1 (0x1021). Each accepted byte is XORed into the upper half of the running value. The register then advances eight steps toward the MSB, so data bit 7 enters first. In any step where bit 15 was set before the shift, the shifted value is XORed with 0x1021. The whole eight-step update settles within one cycle, as a parallel XOR network.

A message opens with a single-cycle `start` pulse. That cycle captures the seeding choice and the reflect flag. The engine can seed in two ways. With `start_seed_en` high, one seed byte is copied into both halves of the register. With it low, the engine continues from a 16-bit value that a previous run produced.

In reflected mode, each data byte is bit-reversed before the update. A carried-over value is bit-reversed across all 16 bits on entry. The result is bit-reversed across all 16 bits on exit. Because of this, the output of one reflected run can be fed back unchanged as the carry-in of the next run.

Bytes arrive on a valid/ready stream and the result leaves on a second one. `in_ready` is high only while a message is open, so the source is held off before `start` and while a result is waiting. `in_end` closes the message. It may share a cycle with the last byte, or come in a later cycle with no byte. The result is then held on `out_crc` with `out_valid` high until the sink raises `out_ready`.

Top module: `crc16_byte_engine`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `out_valid` and `in_ready` are 0 and `out_crc` is 0x0000.
- R2: In normal mode, each accepted byte updates the register as follows. The byte is XORed into bits 15..8, then eight MSB-first shifts follow, each XORed with 0x1021 when bit 15 was 1. Seed byte 0xFF over the ASCII bytes "123456789" yields 0x29B1.
- R3: When `start_seed_en` is 1 at start, the initial register is {`start_seed`, `start_seed`}, whatever the reflect flag.
- R4: When `start_seed_en` is 0, the initial register is `start_crc` in normal mode, and its full 16-bit reversal (bit i goes to bit 15-i) in reflected mode. A message split in two, with the first result fed back as `start_crc`, gives the same result as the whole message.
- R5: In reflected mode, each data byte is bit-reversed (bit i goes to bit 7-i) before it enters the update.
- R6: `out_crc` is the full 16-bit reversal of the final register in reflected mode, and the register unchanged in normal mode.
- R7: `in_ready` is 1 only between an accepted start and the end marker. A byte is taken only when `in_valid` and `in_ready` are both high. Cycles with `in_valid` low do not change the result.
- R8: The result is the same whether `in_end` comes with the last byte or in a later cycle. `out_valid` rises on the cycle after the edge that takes `in_end`. A message with no bytes returns the seeded or converted initial value, passed through the output conversion of R6.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_crc` is stable. After an edge with both high, `out_valid` and `in_ready` are 0 until the next start.
- R10: The reflect flag and seed choice are sampled only at an accepted start. Changes to `start_reflect`, `start_seed_en`, `start_seed` or `start_crc` during a message, and `start` pulses while a message is open, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opens a message when the engine is idle |
| start_reflect | input | 1 | Reflected mode, sampled at start |
| start_seed_en | input | 1 | 1: seed from byte; 0: continue from `start_crc` |
| start_seed | input | 8 | Seed byte copied into both halves |
| start_crc | input | 16 | Carried-over CRC value |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Engine takes a byte this cycle if valid |
| in_data | input | 8 | Input byte |
| in_end | input | 1 | End of message, with or after the last byte |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Sink takes the result |
| out_crc | output | 16 | Registered result |

## Verification
The final byte and the end marker can fall in the same cycle. The bench therefore runs every message in two forms: once with `in_end` raised alongside the last byte, and once with `in_end` raised alone in the cycle after it. Both forms must give the bit-serial reference value computed in the bench. Empty messages, where `in_end` arrives with no byte at all, are judged against the converted seed. Messages with idle gaps and mid-message changes on the start pins are judged against the same reference.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } crc_state_e;
endpackage

// File: rtl/crc16_bitrev.sv
module crc16_bitrev #(
  parameter int W = 8
) (
  input  logic [W-1:0] vec_in,
  output logic [W-1:0] vec_out
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign vec_out[i] = vec_in[W-1-i];
  end
endmodule

// File: rtl/crc16_xor_net.sv
module crc16_xor_net #(
  parameter int CRC_W = 16,
  parameter int DATA_W = 8,
  parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [CRC_W-1:0]  crc_out
);
  localparam int PAD_W = CRC_W - DATA_W;

  logic [CRC_W-1:0] acc;

  always_comb begin
    acc = crc_in ^ {data_in, {PAD_W{1'b0}}};
    for (int k = 0; k < DATA_W; k++) begin
      if (acc[CRC_W-1]) acc = (acc << 1) ^ POLY;
      else              acc = acc << 1;
    end
    crc_out = acc;
  end

  if (CRC_W == 16 && DATA_W == 8 && POLY == 16'h1021) begin : g_eq_chk
    always_comb begin
      if (!$isunknown({crc_in, data_in})) begin
        // Spot checks of the closed-form parallel equations (R2)
        assert_eq_bit0_R2: assert (crc_out[0] ==
          (data_in[4] ^ data_in[0] ^ crc_in[8] ^ crc_in[12]))
          else $error("bit0 equation mismatch");
        assert_eq_bit4_R2: assert (crc_out[4] == (data_in[4] ^ crc_in[12]))
          else $error("bit4 equation mismatch");
        assert_eq_bit8_R2: assert (crc_out[8] ==
          (data_in[7] ^ data_in[3] ^ crc_in[0] ^ crc_in[11] ^ crc_in[15]))
          else $error("bit8 equation mismatch");
      end
    end
  end
endmodule

// File: rtl/crc16_ctrl.sv
module crc16_ctrl
  import crc16_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic in_valid,
  input  logic in_end,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic accept_start,
  output logic take_byte,
  output logic finish
);
  crc_state_e state_q, state_d;

  assign in_ready     = (state_q == ST_RUN);
  assign out_valid    = (state_q == ST_DONE);
  assign accept_start = start && (state_q == ST_IDLE);
  assign take_byte    = in_valid && in_ready;
  assign finish       = in_end && in_ready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start)     state_d = ST_RUN;
      ST_RUN:  if (in_end)    state_d = ST_DONE;
      ST_DONE: if (out_ready) state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid && !in_ready)
    else $error("result handshake did not return to idle");

  assert_end_to_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> out_valid)
    else $error("end marker did not raise out_valid");
endmodule

// File: rtl/crc16_byte_engine.sv
module crc16_byte_engine #(
  parameter int CRC_W = 16,
  parameter int DATA_W = 8,
  parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_reflect,
  input  logic              start_seed_en,
  input  logic [DATA_W-1:0] start_seed,
  input  logic [CRC_W-1:0]  start_crc,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_end,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CRC_W-1:0]  out_crc
);
  localparam int REPL = CRC_W / DATA_W;

  logic accept_start, take_byte, finish;
  logic refl_q;
  logic [CRC_W-1:0] crc_q, out_crc_q;
  logic [CRC_W-1:0] carry_rev, init_val, crc_upd, crc_fin, fin_rev, result;
  logic [DATA_W-1:0] data_rev, data_eff;

  crc16_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .in_valid     (in_valid),
    .in_end       (in_end),
    .out_ready    (out_ready),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .accept_start (accept_start),
    .take_byte    (take_byte),
    .finish       (finish)
  );

  // Entry conversion of a carried-over value
  crc16_bitrev #(.W(CRC_W)) u_rev_entry (.vec_in(start_crc), .vec_out(carry_rev));

  always_comb begin
    if (start_seed_en)      init_val = {REPL{start_seed}};
    else if (start_reflect) init_val = carry_rev;
    else                    init_val = start_crc;
  end

  // Per-byte reflection and update
  crc16_bitrev #(.W(DATA_W)) u_rev_data (.vec_in(in_data), .vec_out(data_rev));
  assign data_eff = refl_q ? data_rev : in_data;

  crc16_xor_net #(.CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY)) u_net (
    .crc_in  (crc_q),
    .data_in (data_eff),
    .crc_out (crc_upd)
  );

  // Exit conversion
  assign crc_fin = take_byte ? crc_upd : crc_q;
  crc16_bitrev #(.W(CRC_W)) u_rev_exit (.vec_in(crc_fin), .vec_out(fin_rev));
  assign result = refl_q ? fin_rev : crc_fin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q     <= '0;
      refl_q    <= 1'b0;
      out_crc_q <= '0;
    end else begin
      if (accept_start) begin
        crc_q  <= init_val;
        refl_q <= start_reflect;
      end else if (take_byte) begin
        crc_q <= crc_upd;
      end
      if (finish) out_crc_q <= result;
    end
  end

  assign out_crc = out_crc_q;

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_crc))
    else $error("result changed while stalled");

  assert_mode_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> $stable(refl_q))
    else $error("reflect mode changed inside a message");

  assert_seed_repl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept_start && start_seed_en |=> crc_q == {REPL{$past(start_seed)}})
    else $error("seed byte not replicated");

  assert_idle_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && !in_valid |=> $stable(crc_q))
    else $error("register moved without a byte");

  assert_normal_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) && !refl_q |-> out_crc == crc_q)
    else $error("normal-mode result differs from register");
endmodule

// File: tb/tb_crc16_byte_engine.sv
module tb_crc16_byte_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, start_reflect = 0, start_seed_en = 0;
  logic [7:0] start_seed = 0;
  logic [15:0] start_crc = 0;
  logic in_valid = 0, in_end = 0, out_ready = 0;
  logic [7:0] in_data = 0;
  logic in_ready, out_valid;
  logic [15:0] out_crc;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [7:0] msg [0:31];
  logic [7:0] full [0:31];
  logic [15:0] last_out;

  always #10 clk = ~clk;

  crc16_byte_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_reflect(start_reflect),
    .start_seed_en(start_seed_en), .start_seed(start_seed), .start_crc(start_crc),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_end(in_end),
    .out_valid(out_valid), .out_ready(out_ready), .out_crc(out_crc)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rv8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  function automatic logic [15:0] rv16(input logic [15:0] b);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = b[15-i];
    return r;
  endfunction

  // Bit-serial reference: one input bit at a time, MSB first
  function automatic logic [15:0] ref_crc(input bit refl, input bit sen,
      input logic [7:0] seed, input logic [15:0] carry, input int len);
    logic [15:0] c;
    logic [7:0] b;
    logic fb;
    c = sen ? {seed, seed} : (refl ? rv16(carry) : carry);
    for (int i = 0; i < len; i++) begin
      b = refl ? rv8(msg[i]) : msg[i];
      for (int k = 7; k >= 0; k--) begin
        fb = c[15] ^ b[k];
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
    end
    return refl ? rv16(c) : c;
  endfunction

  task automatic run_msg(input int len, input bit refl, input bit sen,
      input logic [7:0] seed, input logic [15:0] carry, input bit late_end,
      input bit bubbles, input bit disturb, input string tag);
    logic [15:0] exp, held;
    exp = ref_crc(refl, sen, seed, carry, len);
    @(negedge clk);
    chk(in_ready == 1'b0, "R7 idle in_ready", {31'd0, in_ready}, 0);
    start = 1; start_reflect = refl; start_seed_en = sen;
    start_seed = seed; start_crc = carry;
    @(negedge clk);
    start = 0;
    chk(in_ready == 1'b1, "R7 open in_ready", {31'd0, in_ready}, 1);
    if (disturb) begin
      start = 1; start_reflect = ~refl; start_seed_en = ~sen;
      start_seed = ~seed; start_crc = ~carry;
    end
    for (int i = 0; i < len; i++) begin
      if (bubbles && (i % 3 == 1)) begin
        in_valid = 0; in_data = 8'hA5; in_end = 0;
        @(negedge clk);
      end
      in_valid = 1; in_data = msg[i];
      in_end = (i == len - 1) && !late_end;
      @(negedge clk);
    end
    if (len == 0 || late_end) begin
      in_valid = 0; in_data = 8'h5A; in_end = 1;
      @(negedge clk);
    end
    in_valid = 0; in_end = 0; start = 0;
    chk(out_valid == 1'b1, {tag, " R8 out_valid"}, {31'd0, out_valid}, 1);
    chk(in_ready == 1'b0, "R7 closed in_ready", {31'd0, in_ready}, 0);
    chk(out_crc == exp, tag, {16'd0, out_crc}, {16'd0, exp});
    held = out_crc;
    last_out = out_crc;
    @(negedge clk);
    chk(out_valid == 1'b1 && out_crc == held, "R9 hold", {16'd0, out_crc}, {16'd0, held});
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    chk(out_valid == 1'b0 && in_ready == 1'b0, "R9 release",
        {30'd0, out_valid, in_ready}, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] part;
    int len, cut;
    string chkstr;
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && in_ready == 0 && out_crc == 0, "R1 in reset",
        {15'd0, out_valid, out_crc}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0 && in_ready == 0 && out_crc == 0, "R1 after reset",
        {15'd0, out_valid, out_crc}, 0);

    // R2 check string
    chkstr = "123456789";
    for (int i = 0; i < 9; i++) msg[i] = chkstr[i];
    run_msg(9, 0, 1, 8'hFF, 16'h0, 0, 0, 0, "R2 check string");
    chk(last_out == 16'h29B1, "R2 check value", {16'd0, last_out}, 32'h29B1);
    run_msg(9, 0, 1, 8'hFF, 16'h0, 1, 0, 0, "R8 check string late end");
    chk(last_out == 16'h29B1, "R8 late end value", {16'd0, last_out}, 32'h29B1);

    // Sweep: every byte value under all four mode pairs
    for (int r = 0; r < 2; r++)
      for (int s = 0; s < 2; s++)
        for (int b = 0; b < 256; b++) begin
          msg[0] = b[7:0];
          run_msg(1, r[0], s[0], b[7:0] ^ 8'h3C, {b[7:0], ~b[7:0]}, b[0], 0, 0,
                  r[0] ? (s[0] ? "R5 R3 sweep" : "R5 R4 sweep")
                       : (s[0] ? "R2 R3 sweep" : "R2 R4 sweep"));
        end

    // R8 empty messages
    for (int r = 0; r < 2; r++)
      for (int s = 0; s < 2; s++)
        run_msg(0, r[0], s[0], 8'h81, 16'h1234, 0, 0, 0, "R8 R6 empty");

    // Random messages, gaps and both end placements
    for (int n = 0; n < 300; n++) begin
      len = 1 + ($urandom % 24);
      for (int i = 0; i < len; i++) msg[i] = $urandom;
      run_msg(len, $urandom % 2, $urandom % 2, $urandom, $urandom,
              $urandom % 2, $urandom % 2, 0, "R6 R7 random");
    end

    // R10 start pins disturbed mid-message
    for (int n = 0; n < 20; n++) begin
      len = 2 + ($urandom % 10);
      for (int i = 0; i < len; i++) msg[i] = $urandom;
      run_msg(len, n % 2, (n / 2) % 2, $urandom, $urandom, n % 3 == 0, 0, 1,
              "R10 disturbed");
    end

    // R4 split messages chained through the carried value
    for (int n = 0; n < 40; n++) begin
      len = 4 + ($urandom % 20);
      cut = 1 + ($urandom % (len - 1));
      for (int i = 0; i < len; i++) full[i] = $urandom;
      for (int i = 0; i < cut; i++) msg[i] = full[i];
      run_msg(cut, n % 2, 1, 8'hFF, 16'h0, 0, 0, 0, "R4 first part");
      part = last_out;
      for (int i = 0; i < len - cut; i++) msg[i] = full[cut + i];
      run_msg(len - cut, n % 2, 0, 8'h0, part, 0, 0, 0, "R4 second part");
      for (int i = 0; i < len; i++) msg[i] = full[i];
      chk(last_out == ref_crc(n % 2, 1, 8'hFF, 16'h0, len), "R4 chained",
          {16'd0, last_out}, {16'd0, ref_crc(n % 2, 1, 8'hFF, 16'h0, len)});
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule